// File: doc/BRIEF.md
# Fuse Shadow Loader

After reset this block copies a one-time-programmable fuse array into on-chip shadow registers, one word at a time. It holds the processor in reset until every word has been copied. Software then reads those registers through a read-only window addressed by word. The fuse array holds two regions: a seven-word configuration region at fuse words 0..6 and an eight-word key region at fuse words 7..14. They are fetched in ascending fuse index, so configuration word 0 comes first.

The block takes every fuse word twice over a request/acknowledge handshake and compares the two results. Only a matching pair is written into the shadow storage. A mismatch latches a tamper flag, and the load stops for good. In that case the processor is never released and the policy outputs stay at their secure values.

Two policy bits come from configuration word 0. Bit 17 is the key read lock: it hides the key region from bus reads, while the full key stays available on a dedicated port for hardware. Bit 9 is the debug lock, which keeps the debug port closed. Both outputs come from registers and stay at their secure value (1) until the load has finished.

Top module: `fuse_shadow_loader`

## Requirements
- R1: While reset is asserted and just after it is released, `loadDone`, `cpuRelease` and `tamperFlag` are 0, and `keyRdLock` and `dbgLock` are 1.
- R2: Fuse words are requested in ascending index 0 to 14, and each index is requested exactly twice in a row, giving 30 fuse reads per load.
- R3: `fuseReq` stays high with a stable `fuseAddr` until `fuseAck` is seen. The load completes for any acknowledge latency from 1 to 8 cycles.
- R4: Once all words are copied and checked, `loadDone` and `cpuRelease` go high together and stay high. Configuration word n then reads at byte address 4·n, and a read returns its data on `busRdData` in the cycle after `busRdEn`.
- R5: A bus read issued while `loadDone` is 0 returns all zeros.
- R6: After load, `keyRdLock` equals bit 17 of configuration word 0. When it is 1, reads of key word n at byte address 0x40+4·n return zero. When it is 0, those reads return the key word. `keyOut` bits [32·n+31:32·n] carry key word n in either case.
- R7: After load, `dbgLock` equals bit 9 of configuration word 0 and no longer changes.
- R8: If the two reads of any fuse word differ, `tamperFlag` goes to 1 and stays there. `loadDone` and `cpuRelease` stay 0, and `keyRdLock` and `dbgLock` stay 1.
- R9: Until `loadDone` rises, `keyRdLock` and `dbgLock` are 1, whatever has already been loaded.
- R10: Reads of byte addresses that map to no shadow word return zero. These include 0x1C (past the configuration region) and 0x60 (past the key region).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fuseReq | output | 1 | Fuse word read request |
| fuseAddr | output | 4 | Fuse word index being requested |
| fuseAck | input | 1 | One-cycle acknowledge carrying valid `fuseData` |
| fuseData | input | 32 | Fuse word returned with the acknowledge |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | 8 | Bus byte address; the two low bits are ignored |
| busRdData | output | 32 | Read data, valid the cycle after `busRdEn` |
| loadDone | output | 1 | All words copied and verified |
| cpuRelease | output | 1 | Lets the processor leave reset |
| tamperFlag | output | 1 | Sticky flag for a mismatch between duplicate reads |
| keyRdLock | output | 1 | Key region hidden from bus reads |
| dbgLock | output | 1 | Debug port kept closed |
| keyOut | output | 256 | Key words for hardware consumers, zero before load |

## Verification
Five configuration patterns for word 0 are loaded with acknowledge latencies of 1, 2, 3, 5 and 8 cycles. Together they set the read lock and debug lock bits in all four combinations. One pattern sets every bit except the two policy bits, which shows that the policy logic selects the right bit positions and not just any set bit. Within each load, key reads that are returned and key reads that are hidden show the effect of the lock bit, and reads at both ends of each region and just past them test the decoder edges.

Directed runs then check the following:
- a load with slow acknowledges keeps the policy secure and the bus silent part-way through;
- a corrupted first read and a corrupted second read each latch tamper;
- a tampered load whose fuses request open policy still keeps the outputs secure.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  // Strobes issued by the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic capFirst;    // latch the first read of the current word
    logic commitWord;  // second read matched: write shadow word
    logic setTamper;   // second read differed: latch tamper
    logic finish;      // all words stored: release and apply policy
  } fslStrobe_t;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_RD_A,
    ST_GAP_A,
    ST_RD_B,
    ST_GAP_B,
    ST_FINISH,
    ST_DONE,
    ST_TAMPER
  } fslState_t;

endpackage

// File: rtl/fsl_ctrl.sv
module fsl_ctrl import fsl_pkg::*; #(
  parameter int TOTAL_WORDS = 15,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fuseAck,
  input  logic             wordMatch,
  output logic             fuseReq,
  output logic [IDX_W-1:0] wordIdx,
  output fslStrobe_t       strobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_WORDS - 1);

  fslState_t state, stateNext;
  logic [IDX_W-1:0] idxNext;

  always_comb begin
    stateNext = state;
    idxNext   = wordIdx;
    strobe    = '0;
    case (state)
      ST_BOOT:  stateNext = ST_RD_A;
      ST_RD_A: begin
        if (fuseAck) begin
          strobe.capFirst = 1'b1;
          stateNext       = ST_GAP_A;
        end
      end
      ST_GAP_A: stateNext = ST_RD_B;
      ST_RD_B: begin
        if (fuseAck) begin
          if (wordMatch) begin
            strobe.commitWord = 1'b1;
            if (wordIdx == LAST_IDX) begin
              stateNext = ST_FINISH;
            end else begin
              idxNext   = wordIdx + 1'b1;
              stateNext = ST_GAP_B;
            end
          end else begin
            strobe.setTamper = 1'b1;
            stateNext        = ST_TAMPER;
          end
        end
      end
      ST_GAP_B: stateNext = ST_RD_A;
      ST_FINISH: begin
        strobe.finish = 1'b1;
        stateNext     = ST_DONE;
      end
      ST_DONE:   stateNext = ST_DONE;
      ST_TAMPER: stateNext = ST_TAMPER;
      default:   stateNext = ST_TAMPER;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_BOOT;
      wordIdx <= '0;
    end else begin
      state   <= stateNext;
      wordIdx <= idxNext;
    end
  end

  assign fuseReq = (state == ST_RD_A) || (state == ST_RD_B);

endmodule

// File: rtl/fsl_datapath.sv
module fsl_datapath import fsl_pkg::*; #(
  parameter int DATA_W        = 32,
  parameter int CFG_WORDS     = 7,
  parameter int KEY_WORDS     = 8,
  parameter int ADDR_W        = 8,
  parameter int CFG_BASE_WORD = 0,
  parameter int KEY_BASE_WORD = 16,
  parameter int LOCK_WORD     = 0,
  parameter int LOCK_BIT      = 17,
  parameter int DBG_WORD      = 0,
  parameter int DBG_BIT       = 9,
  parameter int IDX_W         = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fslStrobe_t                  strobe,
  input  logic [IDX_W-1:0]            wordIdx,
  input  logic [DATA_W-1:0]           fuseData,
  input  logic                        busRdEn,
  input  logic [ADDR_W-1:0]           busAddr,
  output logic                        wordMatch,
  output logic [DATA_W-1:0]           busRdData,
  output logic                        loadDone,
  output logic                        tamperFlag,
  output logic                        keyRdLock,
  output logic                        dbgLock,
  output logic [KEY_WORDS*DATA_W-1:0] keyOut
);

  localparam int TOTAL_WORDS = CFG_WORDS + KEY_WORDS;
  localparam int WADDR_W     = ADDR_W - 2;

  logic [DATA_W-1:0] shadow [TOTAL_WORDS];
  logic [DATA_W-1:0] firstRead;
  logic [DATA_W-1:0] rdNext;
  logic [WADDR_W-1:0] wAddr;
  logic unusedAddrLsb;

  // Duplicate-read comparison
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                firstRead <= '0;
    else if (strobe.capFirst) firstRead <= fuseData;
  end

  assign wordMatch = (fuseData == firstRead);

  // Shadow storage, written only with a verified word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < TOTAL_WORDS; w++) shadow[w] <= '0;
    end else if (strobe.commitWord) begin
      for (int w = 0; w < TOTAL_WORDS; w++)
        if (wordIdx == IDX_W'(w)) shadow[w] <= fuseData;
    end
  end

  // Completion, tamper and policy registers (secure value on reset)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadDone   <= 1'b0;
      tamperFlag <= 1'b0;
      keyRdLock  <= 1'b1;
      dbgLock    <= 1'b1;
    end else begin
      if (strobe.setTamper) tamperFlag <= 1'b1;
      if (strobe.finish && !tamperFlag) begin
        loadDone  <= 1'b1;
        keyRdLock <= shadow[LOCK_WORD][LOCK_BIT];
        dbgLock   <= shadow[DBG_WORD][DBG_BIT];
      end
    end
  end

  // Bus read decoder
  assign wAddr         = busAddr[ADDR_W-1:2];
  assign unusedAddrLsb = ^busAddr[1:0];

  always_comb begin
    rdNext = '0;
    if (loadDone) begin
      for (int n = 0; n < CFG_WORDS; n++)
        if (wAddr == WADDR_W'(CFG_BASE_WORD + n)) rdNext = shadow[n];
      for (int n = 0; n < KEY_WORDS; n++)
        if (wAddr == WADDR_W'(KEY_BASE_WORD + n))
          rdNext = keyRdLock ? '0 : shadow[CFG_WORDS + n];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busRdData <= '0;
    else if (busRdEn) busRdData <= rdNext;
  end

  // Hardware key port
  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_keyOut
    assign keyOut[k*DATA_W +: DATA_W] = loadDone ? shadow[CFG_WORDS + k] : '0;
  end

endmodule

// File: rtl/fuse_shadow_loader.sv
module fuse_shadow_loader import fsl_pkg::*; #(
  parameter int DATA_W        = 32,
  parameter int CFG_WORDS     = 7,
  parameter int KEY_WORDS     = 8,
  parameter int ADDR_W        = 8,
  parameter int CFG_BASE_WORD = 0,
  parameter int KEY_BASE_WORD = 16,
  parameter int LOCK_WORD     = 0,
  parameter int LOCK_BIT      = 17,
  parameter int DBG_WORD      = 0,
  parameter int DBG_BIT       = 9,
  localparam int TOTAL_WORDS  = CFG_WORDS + KEY_WORDS,
  localparam int IDX_W        = $clog2(TOTAL_WORDS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  output logic                        fuseReq,
  output logic [IDX_W-1:0]            fuseAddr,
  input  logic                        fuseAck,
  input  logic [DATA_W-1:0]           fuseData,
  input  logic                        busRdEn,
  input  logic [ADDR_W-1:0]           busAddr,
  output logic [DATA_W-1:0]           busRdData,
  output logic                        loadDone,
  output logic                        cpuRelease,
  output logic                        tamperFlag,
  output logic                        keyRdLock,
  output logic                        dbgLock,
  output logic [KEY_WORDS*DATA_W-1:0] keyOut
);

  fslStrobe_t strobe;
  logic       wordMatch;

  fsl_ctrl #(
    .TOTAL_WORDS(TOTAL_WORDS),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fuseAck  (fuseAck),
    .wordMatch(wordMatch),
    .fuseReq  (fuseReq),
    .wordIdx  (fuseAddr),
    .strobe   (strobe)
  );

  fsl_datapath #(
    .DATA_W       (DATA_W),
    .CFG_WORDS    (CFG_WORDS),
    .KEY_WORDS    (KEY_WORDS),
    .ADDR_W       (ADDR_W),
    .CFG_BASE_WORD(CFG_BASE_WORD),
    .KEY_BASE_WORD(KEY_BASE_WORD),
    .LOCK_WORD    (LOCK_WORD),
    .LOCK_BIT     (LOCK_BIT),
    .DBG_WORD     (DBG_WORD),
    .DBG_BIT      (DBG_BIT),
    .IDX_W        (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wordIdx   (fuseAddr),
    .fuseData  (fuseData),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .wordMatch (wordMatch),
    .busRdData (busRdData),
    .loadDone  (loadDone),
    .tamperFlag(tamperFlag),
    .keyRdLock (keyRdLock),
    .dbgLock   (dbgLock),
    .keyOut    (keyOut)
  );

  assign cpuRelease = loadDone;

endmodule

// File: rtl/fsl_checker.sv
module fsl_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              fuseReq,
  input logic              fuseAck,
  input logic [IDX_W-1:0]  fuseAddr,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              loadDone,
  input logic              cpuRelease,
  input logic              tamperFlag,
  input logic              keyRdLock,
  input logic              dbgLock
);

  AST_REQ_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    fuseReq && !fuseAck |=> fuseReq && $stable(fuseAddr)); // R3

  AST_RELEASE_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRelease == loadDone); // R4

  AST_EARLY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && !loadDone |=> busRdData == '0); // R5

  AST_POLICY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone && $stable(keyRdLock) && $stable(dbgLock)); // R7

  AST_TAMPER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    tamperFlag |=> tamperFlag); // R8

  AST_TAMPER_BLOCKS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    tamperFlag |-> !loadDone && !cpuRelease && keyRdLock && dbgLock); // R8

  AST_SECURE_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !loadDone |-> keyRdLock && dbgLock); // R9

endmodule

bind fuse_shadow_loader fsl_checker #(
  .DATA_W(DATA_W),
  .IDX_W (IDX_W)
) u_fslChecker (
  .clk       (clk),
  .rstN      (rstN),
  .fuseReq   (fuseReq),
  .fuseAck   (fuseAck),
  .fuseAddr  (fuseAddr),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .loadDone  (loadDone),
  .cpuRelease(cpuRelease),
  .tamperFlag(tamperFlag),
  .keyRdLock (keyRdLock),
  .dbgLock   (dbgLock)
);

// File: tb/fuse_shadow_loader_bench.sv
module fuse_shadow_loader_bench;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int CFG_WORDS = 7;
  localparam int KEY_WORDS = 8;
  localparam int TOTAL     = CFG_WORDS + KEY_WORDS;
  localparam int IDX_W     = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                        rstN = 1'b0;
  logic                        fuseReq;
  logic [IDX_W-1:0]            fuseAddr;
  logic                        fuseAck = 1'b0;
  logic [DATA_W-1:0]           fuseData = '0;
  logic                        busRdEn = 1'b0;
  logic [ADDR_W-1:0]           busAddr = '0;
  logic [DATA_W-1:0]           busRdData;
  logic                        loadDone, cpuRelease, tamperFlag, keyRdLock, dbgLock;
  logic [KEY_WORDS*DATA_W-1:0] keyOut;

  fuse_shadow_loader u_fuse_shadow_loader (
    .clk(clk), .rstN(rstN), .fuseReq(fuseReq), .fuseAddr(fuseAddr),
    .fuseAck(fuseAck), .fuseData(fuseData), .busRdEn(busRdEn), .busAddr(busAddr),
    .busRdData(busRdData), .loadDone(loadDone), .cpuRelease(cpuRelease),
    .tamperFlag(tamperFlag), .keyRdLock(keyRdLock), .dbgLock(dbgLock), .keyOut(keyOut)
  );

  int compared = 0;
  int mismatched = 0;

  // ---------------- fuse array model: bits can only be burnt to 1 ----------------
  logic [DATA_W-1:0] fuseMem [TOTAL];
  int          waitCyc = 1;
  int          cnt = 0;
  logic        served = 1'b0;
  int          readNo = 0;
  int          orderErr = 0;
  int          glitchRead = -1;
  logic [31:0] glitchMask = '0;

  always @(posedge clk) begin
    fuseAck <= 1'b0;
    if (!rstN) begin
      cnt <= 0; served <= 1'b0; readNo <= 0; orderErr <= 0;
    end else if (!fuseReq) begin
      cnt <= 0; served <= 1'b0;
    end else if (!served) begin
      if (cnt >= waitCyc - 1) begin
        fuseAck  <= 1'b1;
        served   <= 1'b1;
        fuseData <= fuseMem[fuseAddr] ^ ((readNo == glitchRead) ? glitchMask : 32'h0);
        if (int'(fuseAddr) != readNo / 2) orderErr <= orderErr + 1;
        readNo <= readNo + 1;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  function automatic logic [31:0] cfgWord(input int n);
    return 32'h1000_0000 + n * 32'h0011_0101;
  endfunction

  function automatic logic [31:0] keyWord(input int k);
    return 32'hA500_0000 ^ (k * 32'h0101_0137);
  endfunction

  task automatic burn(input int idx, input logic [31:0] val);
    fuseMem[idx] = fuseMem[idx] | val;
  endtask

  task automatic programDie(input logic [31:0] cfg0);
    for (int i = 0; i < TOTAL; i++) fuseMem[i] = '0;  // a fresh, unburnt die
    burn(0, cfg0);
    for (int n = 1; n < CFG_WORDS; n++) burn(n, cfgWord(n));
    for (int k = 0; k < KEY_WORDS; k++) burn(CFG_WORDS + k, keyWord(k));
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busRdEn = 1'b0; busAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busRead(input logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = addr;
    @(negedge clk);
    busRdEn = 1'b0;
    data = busRdData;
  endtask

  task automatic waitDone(input int limit);
    for (int c = 0; c < limit && !loadDone; c++) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // ---------------- stimulus / expected table ----------------
  typedef struct packed {
    logic [3:0]  wait_;
    logic [31:0] cfg0;
    logic        expKeyLock;
    logic        expDbg;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{wait_: 4'd1, cfg0: 32'h0002_0200, expKeyLock: 1'b1, expDbg: 1'b1},
    '{wait_: 4'd3, cfg0: 32'h0000_0100, expKeyLock: 1'b0, expDbg: 1'b0},
    '{wait_: 4'd8, cfg0: 32'h0002_0000, expKeyLock: 1'b1, expDbg: 1'b0},
    '{wait_: 4'd5, cfg0: 32'h0000_0200, expKeyLock: 1'b0, expDbg: 1'b1},
    '{wait_: 4'd2, cfg0: 32'hFFFD_FDFF, expKeyLock: 1'b0, expDbg: 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;

    // R1: reset state
    programDie(32'h0);
    waitCyc = 1;
    doReset();
    check("R1 loadDone after reset", {31'b0, loadDone}, 32'd0);
    check("R1 cpuRelease after reset", {31'b0, cpuRelease}, 32'd0);
    check("R1 tamperFlag after reset", {31'b0, tamperFlag}, 32'd0);
    check("R1 keyRdLock after reset", {31'b0, keyRdLock}, 32'd1);
    check("R1 dbgLock after reset", {31'b0, dbgLock}, 32'd1);

    // Table walk: R2 R3 R4 R6 R7 R10
    for (int v = 0; v < 5; v++) begin
      programDie(VECS[v].cfg0);
      waitCyc = int'(VECS[v].wait_);
      glitchRead = -1;
      doReset();
      waitDone(2000);
      check($sformatf("R3 R4 loadDone vec%0d", v), {31'b0, loadDone}, 32'd1);
      check($sformatf("R4 cpuRelease vec%0d", v), {31'b0, cpuRelease}, 32'd1);
      check($sformatf("R2 order errors vec%0d", v), orderErr, 32'd0);
      check($sformatf("R2 fuse read count vec%0d", v), readNo, 32'd30);
      check($sformatf("R6 keyRdLock vec%0d", v), {31'b0, keyRdLock}, {31'b0, VECS[v].expKeyLock});
      check($sformatf("R7 dbgLock vec%0d", v), {31'b0, dbgLock}, {31'b0, VECS[v].expDbg});
      busRead(8'h00, rd);
      check($sformatf("R4 cfg word0 vec%0d", v), rd, VECS[v].cfg0);
      busRead(8'h18, rd);
      check($sformatf("R4 cfg word6 vec%0d", v), rd, cfgWord(6));
      busRead(8'h48, rd);
      check($sformatf("R6 key word2 bus vec%0d", v), rd,
            VECS[v].expKeyLock ? 32'h0 : keyWord(2));
      busRead(8'h5C, rd);
      check($sformatf("R6 key word7 bus vec%0d", v), rd,
            VECS[v].expKeyLock ? 32'h0 : keyWord(7));
      check($sformatf("R6 keyOut word2 vec%0d", v), keyOut[2*DATA_W +: DATA_W], keyWord(2));
      busRead(8'h1C, rd);
      check($sformatf("R10 unmapped 0x1C vec%0d", v), rd, 32'h0);
      busRead(8'h60, rd);
      check($sformatf("R10 unmapped 0x60 vec%0d", v), rd, 32'h0);
      repeat (5) @(negedge clk);
      check($sformatf("R7 dbgLock held vec%0d", v), {31'b0, dbgLock}, {31'b0, VECS[v].expDbg});
    end

    // R9 and R5: slow load, probe part-way through
    programDie(32'h0);
    waitCyc = 8;
    glitchRead = -1;
    doReset();
    repeat (60) @(negedge clk);
    check("R9 keyRdLock mid-load", {31'b0, keyRdLock}, 32'd1);
    check("R9 dbgLock mid-load", {31'b0, dbgLock}, 32'd1);
    busRead(8'h04, rd);
    check("R5 early read cfg word1", rd, 32'h0);
    busRead(8'h40, rd);
    check("R5 early read key word0", rd, 32'h0);
    waitDone(2000);
    check("R9 keyRdLock opens after load", {31'b0, keyRdLock}, 32'd0);
    check("R9 dbgLock opens after load", {31'b0, dbgLock}, 32'd0);
    busRead(8'h04, rd);
    check("R4 cfg word1 after load", rd, cfgWord(1));

    // R8: corrupted second read of fuse word 2, open policy requested
    programDie(32'h0);
    waitCyc = 2;
    glitchRead = 5;
    glitchMask = 32'h0000_0040;
    doReset();
    repeat (600) @(negedge clk);
    check("R8 tamperFlag (2nd read)", {31'b0, tamperFlag}, 32'd1);
    check("R8 loadDone stays low", {31'b0, loadDone}, 32'd0);
    check("R8 cpuRelease stays low", {31'b0, cpuRelease}, 32'd0);
    check("R8 keyRdLock stays secure", {31'b0, keyRdLock}, 32'd1);
    check("R8 dbgLock stays secure", {31'b0, dbgLock}, 32'd1);
    busRead(8'h00, rd);
    check("R5 read while tampered", rd, 32'h0);

    // R8: corrupted first read of the last key word
    programDie(32'h0002_0200);
    waitCyc = 1;
    glitchRead = 28;
    glitchMask = 32'h8000_0000;
    doReset();
    repeat (600) @(negedge clk);
    check("R8 tamperFlag (1st read)", {31'b0, tamperFlag}, 32'd1);
    check("R8 loadDone low (1st read)", {31'b0, loadDone}, 32'd0);
    check("R8 keyOut hidden", keyOut[7*DATA_W +: DATA_W], 32'h0);

    // R1: reset after tamper clears the flag
    glitchRead = -1;
    doReset();
    check("R1 tamperFlag cleared by reset", {31'b0, tamperFlag}, 32'd0);
    waitDone(2000);
    check("R4 clean load after tamper", {31'b0, loadDone}, 32'd1);

    summary();
    $finish;
  end

endmodule